// File: doc/BRIEF.md
# Motion Delta Report Registers

This block sits between a motion engine and a register port. Each frame the motion engine presents a signed X increment and a signed Y increment with a one-cycle valid strobe. The block adds them into two 8-bit report accumulators that saturate at the ends of the two's complement range. A host reads the totals through a simple register port: a read strobe, a write strobe, a 7-bit address and a registered read-data bus. Reading a delta clears it. A status register carries a sticky motion flag that tells the host whether a report is waiting.

Reading X and Y as two separate transfers could split one frame's motion between two reports. Reading X therefore moves the live Y total into a holding register, and the next Y read returns that copy. A 16-bit shutter value from the imaging side is read the same way: the upper byte first, which freezes the lower byte for the read that follows. A write of any value to the status address drops every pending report at once.

Top module: `motion_delta_regs`

## Requirements
- R1: After reset the status register reads 0x00, both delta registers read 0x00, and no snapshot is pending.
- R2: On every cycle with `frame_vld` high, `dx_inc` and `dy_inc` are added as 8-bit two's complement values into the X and Y accumulators.
- R3: Accumulation saturates: a sum above +127 holds at +127 (0x7F), and a sum below −128 holds at −128 (0x80).
- R4: A read of address 0x02 returns the motion flag in bit 7 with bits 6:0 zero. The flag is set by any valid frame with a nonzero X or Y increment. A frame with both increments zero does not set it.
- R5: A read of address 0x03 returns the X total and clears it. In the same cycle the live Y total is copied into a holding register and the live Y accumulator is cleared.
- R6: A read of address 0x04 returns the held Y copy if one is pending and consumes it. With no copy pending, it returns the live Y total and clears it.
- R7: An increment that arrives in the same cycle as a clear (by read or by write) is added to the cleared accumulator, so it is not lost.
- R8: On a read of 0x04 the motion flag clears if both accumulators are zero after that cycle. Otherwise the flag stays set.
- R9: A write of any value to 0x02 clears the flag, both accumulators and the held Y copy. The written byte is not kept, and increments arriving in the same cycle are kept.
- R10: A read of 0x06 returns shutter bits 15:8 and latches bits 7:0. The next read of 0x07 returns the latched byte once. A read of 0x07 with nothing latched returns live bits 7:0.
- R11: `rdata` changes only in the cycle after a read strobe and otherwise holds its value. A read of any other address returns 0x00. A write to any address other than 0x02 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| wr_en | input | 1 | Register write strobe, one cycle per access |
| addr | input | 7 | Register address |
| frame_vld | input | 1 | Per-frame increment valid strobe |
| dx_inc | input | 8 | Signed X increment for this frame |
| dy_inc | input | 8 | Signed Y increment for this frame |
| shutter | input | 16 | Live shutter value from the imaging side |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
An accumulator or snapshot state that has gone wrong stays hidden until the host reads it. It then shows up on `rdata` exactly one cycle after that read strobe, either as a wrong delta or as a held Y value that belongs to a different X read. A wrong motion flag shows on the next status read. A flag that fails to clear shows after a Y read that empties both totals. The random mix therefore interleaves frames, reads in both orders, clears and shutter pairs densely, so that every state is read back within a few cycles of being changed.

// File: rtl/mdacc_pkg.sv
package mdacc_pkg;

    localparam int unsigned ADR_W = 7;

    localparam logic [ADR_W-1:0] ADR_STATUS = 7'h02;
    localparam logic [ADR_W-1:0] ADR_DX     = 7'h03;
    localparam logic [ADR_W-1:0] ADR_DY     = 7'h04;
    localparam logic [ADR_W-1:0] ADR_SH_HI  = 7'h06;
    localparam logic [ADR_W-1:0] ADR_SH_LO  = 7'h07;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_DX,
        SEL_DY,
        SEL_SH_HI,
        SEL_SH_LO
    } reg_sel_e;

endpackage

// File: rtl/mdacc_accum.sv
module mdacc_accum #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] inc,
    output logic [W-1:0] val,
    output logic [W-1:0] val_next
);

    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [W-1:0] base;
    logic [W:0]   wide_sum;

    always_comb begin
        st_d     = st_q;
        base     = clr ? '0 : st_q.acc;
        wide_sum = {base[W-1], base} + {inc[W-1], inc};
        if (add_en) begin
            if (wide_sum[W] != wide_sum[W-1]) begin
                st_d.acc = wide_sum[W] ? NEG_LIM : POS_LIM;
            end else begin
                st_d.acc = wide_sum[W-1:0];
            end
        end else begin
            st_d.acc = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val      = st_q.acc;
    assign val_next = st_d.acc;

endmodule

// File: rtl/mdacc_snap.sv
module mdacc_snap #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drop,
    input  logic         capture,
    input  logic [W-1:0] din,
    input  logic         consume,
    output logic [W-1:0] held,
    output logic         held_vld
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         vld;
    } snap_state_t;

    snap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drop) begin
            st_d.vld = 1'b0;
        end else if (capture) begin
            st_d.data = din;
            st_d.vld  = 1'b1;
        end else if (consume) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held     = st_q.data;
    assign held_vld = st_q.vld;

endmodule

// File: rtl/motion_delta_regs.sv
module motion_delta_regs
    import mdacc_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic             frame_vld,
    input  logic [DW-1:0]    dx_inc,
    input  logic [DW-1:0]    dy_inc,
    input  logic [SW-1:0]    shutter,
    output logic [DW-1:0]    rdata
);

    localparam int unsigned HW = SW / 2;

    typedef struct packed {
        logic          mot;
        logic [DW-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    reg_sel_e sel;
    logic rd_x, rd_y, rd_hi, rd_lo, wr_clr, set_mot;
    logic [DW-1:0] x_val, x_nxt, y_val, y_nxt, y_held;
    logic [HW-1:0] sh_held;
    logic y_held_vld, sh_held_vld;
    logic x_clr, y_clr;

    always_comb begin
        unique case (addr)
            ADR_STATUS: sel = SEL_STATUS;
            ADR_DX:     sel = SEL_DX;
            ADR_DY:     sel = SEL_DY;
            ADR_SH_HI:  sel = SEL_SH_HI;
            ADR_SH_LO:  sel = SEL_SH_LO;
            default:    sel = SEL_NONE;
        endcase
    end

    assign rd_x    = rd_en && (sel == SEL_DX);
    assign rd_y    = rd_en && (sel == SEL_DY);
    assign rd_hi   = rd_en && (sel == SEL_SH_HI);
    assign rd_lo   = rd_en && (sel == SEL_SH_LO);
    assign wr_clr  = wr_en && (sel == SEL_STATUS);
    assign set_mot = frame_vld && ((|dx_inc) || (|dy_inc));

    assign x_clr = rd_x || wr_clr;
    assign y_clr = rd_x || wr_clr || (rd_y && !y_held_vld);

    mdacc_accum #(.W(DW)) u_acc_x (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (x_clr),
        .add_en   (frame_vld),
        .inc      (dx_inc),
        .val      (x_val),
        .val_next (x_nxt)
    );

    mdacc_accum #(.W(DW)) u_acc_y (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (y_clr),
        .add_en   (frame_vld),
        .inc      (dy_inc),
        .val      (y_val),
        .val_next (y_nxt)
    );

    mdacc_snap #(.W(DW)) u_snap_y (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop     (wr_clr),
        .capture  (rd_x),
        .din      (y_val),
        .consume  (rd_y),
        .held     (y_held),
        .held_vld (y_held_vld)
    );

    mdacc_snap #(.W(HW)) u_snap_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop     (1'b0),
        .capture  (rd_hi),
        .din      (shutter[HW-1:0]),
        .consume  (rd_lo),
        .held     (sh_held),
        .held_vld (sh_held_vld)
    );

    always_comb begin
        st_d = st_q;

        if (wr_clr) begin
            st_d.mot = set_mot;
        end else if (set_mot) begin
            st_d.mot = 1'b1;
        end else if (rd_y) begin
            st_d.mot = (x_nxt != '0) || (y_nxt != '0);
        end

        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: st_d.rdata = {st_q.mot, {(DW-1){1'b0}}};
                SEL_DX:     st_d.rdata = x_val;
                SEL_DY:     st_d.rdata = y_held_vld ? y_held : y_val;
                SEL_SH_HI:  st_d.rdata = shutter[SW-1:HW];
                SEL_SH_LO:  st_d.rdata = sh_held_vld ? sh_held : shutter[HW-1:0];
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/motion_delta_regs_chk.sv
module motion_delta_regs_chk
    import mdacc_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic [ADR_W-1:0] addr,
    input logic             frame_vld,
    input logic [DW-1:0]    dx_inc,
    input logic [DW-1:0]    dy_inc,
    input logic [SW-1:0]    shutter,
    input logic [DW-1:0]    rdata,
    input logic             mot
);

    logic nz_frame;
    logic known_addr;
    assign nz_frame   = frame_vld && ((|dx_inc) || (|dy_inc));
    assign known_addr = (addr == ADR_STATUS) || (addr == ADR_DX) || (addr == ADR_DY)
                     || (addr == ADR_SH_HI) || (addr == ADR_SH_LO);

    p_status_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_STATUS) |=> (rdata[DW-2:0] == '0));

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nz_frame |=> mot);

    p_write_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_STATUS && !nz_frame) |=> !mot);

    p_rdata_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !known_addr) |=> (rdata == '0));

    p_shutter_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_SH_HI) |=> (rdata == $past(shutter[SW-1:SW/2])));

endmodule

bind motion_delta_regs motion_delta_regs_chk #(.DW(DW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .frame_vld (frame_vld),
    .dx_inc    (dx_inc),
    .dy_inc    (dy_inc),
    .shutter   (shutter),
    .rdata     (rdata),
    .mot       (st_q.mot)
);

// File: tb/motion_delta_regs_bench.sv
`timescale 1ns/1ps
module motion_delta_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic        frame_vld = 1'b0;
    logic [7:0]  dx_inc = '0;
    logic [7:0]  dy_inc = '0;
    logic [15:0] shutter = '0;
    logic [7:0]  rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int   m_x = 0, m_y = 0, m_h = 0;
    bit   m_hv = 0, m_mot = 0, m_slv = 0;
    logic [7:0] m_sl = '0;
    logic [7:0] m_rd = '0;

    always #4 clk = ~clk;

    motion_delta_regs u_motion_delta_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .frame_vld (frame_vld),
        .dx_inc    (dx_inc),
        .dy_inc    (dy_inc),
        .shutter   (shutter),
        .rdata     (rdata)
    );

    function automatic int sat8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic string tag_of(input bit rd, input logic [6:0] a);
        if (!rd) return "R11";
        case (a)
            7'h02: return "R4";
            7'h03: return "R5";
            7'h04: return "R6";
            7'h06, 7'h07: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: rdata actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic op(input bit rd, input bit wr, input logic [6:0] a, input bit fv,
                      input int dx, input int dy, input logic [15:0] sh, input string req);
        bit rdx, rdy, rdh, rdl, wrc, setm;
        int nx, ny;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; frame_vld = fv;
        dx_inc = dx[7:0]; dy_inc = dy[7:0]; shutter = sh;
        rdx = rd && a == 7'h03; rdy = rd && a == 7'h04;
        rdh = rd && a == 7'h06; rdl = rd && a == 7'h07;
        wrc = wr && a == 7'h02;
        if (rd) begin
            case (a)
                7'h02: m_rd = {m_mot, 7'b0};
                7'h03: m_rd = m_x[7:0];
                7'h04: m_rd = m_hv ? m_h[7:0] : m_y[7:0];
                7'h06: m_rd = sh[15:8];
                7'h07: m_rd = m_slv ? m_sl : sh[7:0];
                default: m_rd = 8'h00;
            endcase
        end
        nx = (rdx || wrc) ? 0 : m_x;
        ny = (rdx || wrc || (rdy && !m_hv)) ? 0 : m_y;
        if (fv) begin
            nx = sat8(nx + dx);
            ny = sat8(ny + dy);
        end
        setm = fv && (dx != 0 || dy != 0);
        if (wrc) m_mot = setm;
        else if (setm) m_mot = 1;
        else if (rdy) m_mot = (nx != 0 || ny != 0);
        if (wrc) m_hv = 0;
        else if (rdx) begin m_h = m_y; m_hv = 1; end
        else if (rdy) m_hv = 0;
        if (rdh) begin m_sl = sh[7:0]; m_slv = 1; end
        else if (rdl) m_slv = 0;
        m_x = nx; m_y = ny;
        @(posedge clk);
        #1;
        check(rdata == m_rd, req, rdata, m_rd);
    endtask

    task automatic rd(input logic [6:0] a, input string req);
        op(1, 0, a, 0, 0, 0, shutter, req);
    endtask

    task automatic frame(input int dx, input int dy);
        op(0, 0, 7'h00, 1, dx, dy, shutter, "R2");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(7'h02, "R1"); rd(7'h03, "R1"); rd(7'h04, "R1");

        // R2, R4, R5, R6, R8 basic report
        frame(5, -3); frame(10, 1);
        rd(7'h02, "R4"); rd(7'h03, "R5"); rd(7'h04, "R6");
        rd(7'h04, "R6"); rd(7'h02, "R8");

        // R4 zero frame does not set flag
        frame(0, 0); rd(7'h02, "R4");

        // R3 saturation both ends
        frame(100, -100); frame(100, -100); frame(100, -100);
        rd(7'h03, "R3"); rd(7'h04, "R3");

        // R7 increment during clear-on-read
        frame(9, 4);
        op(1, 0, 7'h03, 1, 7, -2, shutter, "R7");
        rd(7'h03, "R7"); rd(7'h04, "R7"); rd(7'h04, "R7");

        // R8 flag held while new motion pending after snapshot
        frame(3, 3); rd(7'h03, "R8"); frame(2, 0);
        rd(7'h04, "R8"); rd(7'h02, "R8");
        rd(7'h03, "R8"); rd(7'h04, "R8"); rd(7'h02, "R8");

        // R9 write clears everything, same-cycle increment kept
        frame(20, 30); rd(7'h03, "R9");
        op(0, 1, 7'h02, 0, 0, 0, shutter, "R9");
        rd(7'h02, "R9"); rd(7'h04, "R9"); rd(7'h03, "R9");
        frame(6, 6);
        op(0, 1, 7'h02, 1, 3, 0, shutter, "R9");
        rd(7'h02, "R9"); rd(7'h03, "R9"); rd(7'h04, "R9");

        // R10 shutter pair
        op(1, 0, 7'h06, 0, 0, 0, 16'hABCD, "R10");
        op(1, 0, 7'h07, 0, 0, 0, 16'h1234, "R10");
        op(1, 0, 7'h07, 0, 0, 0, 16'h5678, "R10");

        // R11 unmapped read, foreign write ignored
        frame(12, -7);
        rd(7'h10, "R11");
        op(0, 1, 7'h03, 0, 0, 0, shutter, "R11");
        op(0, 1, 7'h04, 0, 0, 0, shutter, "R11");
        rd(7'h03, "R11"); rd(7'h04, "R11");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned k;
            bit r, w, f;
            logic [6:0] a;
            int dx, dy;
            k = $urandom % 100;
            r = (k < 45);
            w = (k >= 45 && k < 50);
            f = ($urandom % 3) != 0;
            case ($urandom % 8)
                0: a = 7'h02;
                1, 2: a = 7'h03;
                3, 4: a = 7'h04;
                5: a = 7'h06;
                6: a = 7'h07;
                default: a = 7'($urandom);
            endcase
            if (w && ($urandom % 2 == 0)) a = 7'h02;
            case ($urandom % 4)
                0: begin dx = 0; dy = 0; end
                1: begin dx = int'($urandom % 256) - 128; dy = int'($urandom % 256) - 128; end
                default: begin dx = int'($urandom % 9) - 4; dy = int'($urandom % 9) - 4; end
            endcase
            op(r, w, a, f, dx, dy, 16'($urandom), tag_of(r, a));
        end

        @(negedge clk);
        rd_en = 0; wr_en = 0; frame_vld = 0;
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule